// File: doc/BRIEF.md
# Status Register Write Lock-Down Guard

This block keeps the 8-bit status register of a serial-memory slave. It also decides whether each request to rewrite that register is allowed. Two things settle the decision. One is an active-low hardware write-protect input. The other is a lock-down bit stored inside the register. The lock-down bit can freeze the register only while the pin is held low. With the pin high, the register stays writable whatever the bit holds, so a board-level strap can always recover a locked part.

The command decoder raises a one-cycle request strobe and presents a data byte at the same time. On the next rising clock edge the guard either commits the writable bits or leaves the register untouched. In the cycle after that edge it shows a verdict. The two block-protection bits are exported on their own output, and the array write path uses them to refuse writes to guarded regions.

A small state machine carries the verdict. Its states are ST_IDLE (no request was seen on the last edge), ST_ACCEPTED (the last edge committed a write) and ST_REJECTED (the last edge refused a write). From any state, a request that is permitted moves it to ST_ACCEPTED, a request that is refused moves it to ST_REJECTED, and an edge with no request returns it to ST_IDLE. Reset forces ST_IDLE.

Top module: `sr_guard`

## Requirements
- R1: While rst_n is low, sr_q reads 8'h00, bp_q reads 2'b00, and wr_done and wr_ok are 0.
- R2: With wp_n high, a request is accepted whatever the lock-down bit (bit 7) holds. After the edge that samples wr_req, sr_q equals wr_data masked to the writable bits.
- R3: With wp_n low and the lock-down bit at 0, a request is accepted and updates sr_q on the edge that samples it.
- R4: With wp_n low and the lock-down bit at 1, a request is rejected and sr_q keeps its value.
- R5: Only bit 7 (lock-down), bit 3 (BP1) and bit 2 (BP0) are writable. All other bits always read 0, and writes to them are ignored.
- R6: wr_done is high for the cycle after each edge that samples wr_req high, and low otherwise. During that cycle wr_ok is 1 for an accepted request and 0 for a rejected one. wr_ok is 0 whenever wr_done is 0.
- R7: bp_q[1] mirrors sr_q bit 3 and bp_q[0] mirrors sr_q bit 2 at all times.
- R8: The verdict uses the lock-down value stored before the write. With wp_n low, a write that sets the bit from 0 is accepted, and a write that would clear it from 1 is rejected.
- R9: On an edge with wr_req low, sr_q does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_req | input | 1 | One-cycle request to write the status register |
| wr_data | input | 8 | Byte offered with the request |
| sr_q | output | 8 | Current status register value |
| wr_done | output | 1 | High for one cycle after each request |
| wr_ok | output | 1 | Verdict of that request: 1 accepted, 0 rejected |
| bp_q | output | 2 | Block-protection bits {BP1, BP0} |

## Verification
The hardest case to reach is a register that is locked while the pin is low. It can only be reached in two ways. One is to write the lock-down bit while the pin is high and then pull the pin low. The other is to set the bit with the pin already low. The stimulus walks through both orders. It then tries to clear the lock with the pin low, which must fail, and raises the pin to release it. A mid-run reset with the lock set confirms that the lock does not survive reset. Back-to-back requests check that each verdict uses the lock value committed on the previous edge.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACCEPTED = 2'd1,
        ST_REJECTED = 2'd2
    } guard_state_t;

endpackage

// File: rtl/sr_guard_permit.sv
module sr_guard_permit (
    input  logic wp_n,
    input  logic lock_bit,
    output logic permit
);
    // The pin overrides the stored lock: a high pin always permits
    always_comb begin
        permit = wp_n | ~lock_bit;
    end
endmodule

// File: rtl/sr_guard_fsm.sv
module sr_guard_fsm
    import sr_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic permit,
    output logic commit,
    output logic wr_done,
    output logic wr_ok
);
    guard_state_t state_q;
    guard_state_t state_d;

    always_comb begin
        if (!wr_req) begin
            state_d = ST_IDLE;
        end else if (permit) begin
            state_d = ST_ACCEPTED;
        end else begin
            state_d = ST_REJECTED;
        end
        commit = wr_req & permit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ACCEPTED: begin
                wr_done = 1'b1;
                wr_ok   = 1'b1;
            end
            ST_REJECTED: begin
                wr_done = 1'b1;
                wr_ok   = 1'b0;
            end
            default: begin
                wr_done = 1'b0;
                wr_ok   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sr_guard_store.sv
module sr_guard_store #(
    parameter int SR_W = 8,
    parameter logic [SR_W-1:0] WR_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic [SR_W-1:0] wr_data,
    output logic [SR_W-1:0] sr_q
);
    logic [SR_W-1:0] held_q;

    for (genvar b = 0; b < SR_W; b++) begin : g_bit
        if (WR_MASK[b]) begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    held_q[b] <= 1'b0;
                end else if (commit) begin
                    held_q[b] <= wr_data[b];
                end
            end
        end else begin : g_ro
            // A read-only bit holds 0 and never follows the offered data
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    held_q[b] <= 1'b0;
                end else if (commit) begin
                    held_q[b] <= wr_data[b] & 1'b0;
                end
            end
        end
    end

    assign sr_q = held_q;
endmodule

// File: rtl/sr_guard.sv
module sr_guard #(
    parameter int SR_W     = 8,
    parameter int LOCK_POS = 7,
    parameter int BP_LSB   = 2,
    parameter int BP_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wp_n,
    input  logic            wr_req,
    input  logic [SR_W-1:0] wr_data,
    output logic [SR_W-1:0] sr_q,
    output logic            wr_done,
    output logic            wr_ok,
    output logic [BP_W-1:0] bp_q
);
    localparam logic [SR_W-1:0] LOCK_MASK = SR_W'(1) << LOCK_POS;
    localparam logic [SR_W-1:0] BP_MASK   = SR_W'((1 << BP_W) - 1) << BP_LSB;
    localparam logic [SR_W-1:0] WR_MASK   = LOCK_MASK | BP_MASK;

    logic permit;
    logic commit;

    sr_guard_permit permit_i (
        .wp_n     (wp_n),
        .lock_bit (sr_q[LOCK_POS]),
        .permit   (permit)
    );

    sr_guard_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .permit  (permit),
        .commit  (commit),
        .wr_done (wr_done),
        .wr_ok   (wr_ok)
    );

    sr_guard_store #(
        .SR_W    (SR_W),
        .WR_MASK (WR_MASK)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr_data (wr_data),
        .sr_q    (sr_q)
    );

    assign bp_q = sr_q[BP_LSB +: BP_W];
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk #(
    parameter int SR_W     = 8,
    parameter int LOCK_POS = 7,
    parameter int BP_LSB   = 2,
    parameter int BP_W     = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wp_n,
    input logic            wr_req,
    input logic [SR_W-1:0] wr_data,
    input logic [SR_W-1:0] sr_q,
    input logic            wr_done,
    input logic            wr_ok,
    input logic [BP_W-1:0] bp_q
);
    localparam logic [SR_W-1:0] CHK_MASK =
        (SR_W'(1) << LOCK_POS) | (SR_W'((1 << BP_W) - 1) << BP_LSB);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (sr_q == '0 && !wr_done && !wr_ok));

    a_r2_pin_high_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wp_n) |=> (wr_ok && sr_q == ($past(wr_data) & CHK_MASK)));

    a_r3_unlocked_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wp_n && !sr_q[LOCK_POS]) |=>
            (wr_ok && sr_q == ($past(wr_data) & CHK_MASK)));

    a_r4_locked_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wp_n && sr_q[LOCK_POS]) |=> (!wr_ok && $stable(sr_q)));

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q & ~CHK_MASK) == '0);

    a_r6_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_done);

    a_r6_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> (!wr_done && !wr_ok));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(sr_q));
endmodule

bind sr_guard sr_guard_chk #(
    .SR_W     (SR_W),
    .LOCK_POS (LOCK_POS),
    .BP_LSB   (BP_LSB),
    .BP_W     (BP_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_n    (wp_n),
    .wr_req  (wr_req),
    .wr_data (wr_data),
    .sr_q    (sr_q),
    .wr_done (wr_done),
    .wr_ok   (wr_ok),
    .bp_q    (bp_q)
);

// File: tb/sr_guard_tb_top.sv
module sr_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n = 1'b1;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sr_q;
    logic       wr_done;
    logic       wr_ok;
    logic [1:0] bp_q;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    // Reference state, updated behaviourally from the requirements
    logic [7:0] m_sr = 8'h00;
    logic       m_done = 1'b0;
    logic       m_ok = 1'b0;

    always #5 clk = ~clk;

    sr_guard dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wp_n    (wp_n),
        .wr_req  (wr_req),
        .wr_data (wr_data),
        .sr_q    (sr_q),
        .wr_done (wr_done),
        .wr_ok   (wr_ok),
        .bp_q    (bp_q)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr   = 8'h00;
            m_done = 1'b0;
            m_ok   = 1'b0;
        end else begin
            m_done = wr_req;
            m_ok   = wr_req && (wp_n || !m_sr[7]);
            if (m_ok) m_sr = wr_data & 8'h8C;
        end
        #2;
        check(rst_n ? tag : "R1", "sr_q", sr_q, m_sr);
        check("R5", "reserved bits", sr_q & 8'h73, 0);
        check("R6", "wr_done", wr_done, m_done);
        check("R6", "wr_ok", wr_ok, m_ok);
        check("R7", "bp_q", bp_q, {m_sr[3], m_sr[2]});
    end

    task automatic idle(input int n, input string t);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_req = 1'b0;
            tag = t;
        end
    endtask

    task automatic req(input logic pin, input logic [7:0] d, input string t);
        @(negedge clk);
        wp_n = pin;
        wr_req = 1'b1;
        wr_data = d;
        tag = t;
    endtask

    task automatic wr(input logic pin, input logic [7:0] d, input string t);
        req(pin, d, t);
        idle(1, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R9");
        wr(1'b1, 8'hFF, "R2");      // pin high, all ones: only 0x8C lands
        idle(3, "R9");
        wr(1'b1, 8'h00, "R2");      // pin high clears a set lock
        wr(1'b0, 8'h04, "R3");      // pin low, unlocked
        wr(1'b0, 8'h88, "R8");      // set lock while pin low
        wr(1'b0, 8'h00, "R4");      // clear attempt while locked
        wr(1'b0, 8'h0C, "R4");
        idle(2, "R9");
        wr(1'b1, 8'h84, "R2");      // pin high, lock set: accepted
        wr(1'b0, 8'h00, "R4");      // now pin low: frozen
        wr(1'b1, 8'h08, "R2");      // release through pin
        wr(1'b0, 8'hF7, "R3");
        wr(1'b0, 8'h00, "R4");
        // back-to-back: verdicts use the lock from the previous edge
        req(1'b1, 8'h80, "R2");
        req(1'b0, 8'h00, "R8");
        req(1'b1, 8'h04, "R2");
        req(1'b0, 8'h88, "R8");
        req(1'b0, 8'h0C, "R8");
        idle(2, "R9");
        // toggle pin without a request: no change
        wp_n = 1'b1;
        idle(2, "R9");
        wp_n = 1'b0;
        idle(2, "R9");
        // reset with lock set clears everything
        @(negedge clk);
        rst_n = 1'b0;
        idle(2, "R1");
        rst_n = 1'b1;
        wr(1'b0, 8'h8C, "R3");
        idle(2, "R9");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule